// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block sits beside the fetch and decode logic of a 16-bit processor core and runs the memory traffic for entering and leaving an interrupt handler. When idle it looks at three requests: a return strobe from the decoder, a non-maskable interrupt request, and a maskable interrupt request that carries an 8-bit type. The maskable request only counts while the interrupt-enable bit of the incoming flags word is set. After it accepts an interrupt, the block captures the core's flags, code segment, instruction pointer, stack segment and stack pointer. It then pushes three words to the stack and reads a two-word handler vector from the table at the bottom of memory.

When the sequence ends, the block gives a one-cycle load strobe. The strobe carries the new code segment, instruction pointer, stack pointer and flags, which the core copies into its registers before it fetches again. A return runs the same way in reverse: three pops, then the same load strobe. The block does not own the stack pointer, the flags register or the bus arbiter. It only reads their current values and reports new ones. Memory is reached through a word-wide request/acknowledge port that uses 20-bit physical byte addresses.

Top module: `irq_entry_seq`

## Requirements
- R1: On interrupt entry the block writes the saved flags word first, to stack offset SP-2. It then writes the code segment to SP-4 and the instruction pointer to SP-6. Each physical address is SS*16 plus the offset, truncated to 20 bits.
- R2: After the pushes, the new instruction pointer is read from byte address type*4 and the new code segment from type*4+2. Type 21h therefore uses 84h and 86h, and type 10h uses 40h and 42h.
- R3: The cycle after the second vector word is acknowledged, ctx_load is high for exactly one cycle. In that cycle new_ip and new_cs hold the two vector words, new_sp is the saved SP minus 6, and new_flags is the saved flags with bit 9 (interrupt enable) cleared. busy is low in the cycle after ctx_load.
- R4: While flags_in bit 9 is 0, a maskable request starts no memory access and never raises busy or ctx_load.
- R5: A non-maskable request is serviced whatever flags_in bit 9 holds. It uses type 2, so its vector is at 08h and 0Ah. A one-cycle pulse that arrives while the block is busy is remembered and serviced once the block is idle again.
- R6: When non-maskable and maskable requests are both present in the same idle cycle, the non-maskable one is serviced. The maskable request is then held off, because the interrupt-enable bit was cleared on entry.
- R7: A return reads the instruction pointer from SS:SP, the code segment from SP+2 and the flags from SP+4. ctx_load then carries those three words and new_sp = SP+6.
- R8: A return strobe, or one remembered because it arrived while busy, is served before any interrupt request pending in the same idle cycle.
- R9: While mem_req is high and mem_ack is low, mem_req, mem_addr, mem_we and mem_wdata keep their values. Each acknowledged cycle completes exactly one word. mem_we is high only for the three pushes.
- R10: While reset is held, and in the first cycle after it is released, busy, mem_req and ctx_load are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 1 | Maskable interrupt request (level) |
| irq_type | input | 8 | Type of the maskable request |
| nmi_req | input | 1 | Non-maskable interrupt request (pulse or level) |
| iret_req | input | 1 | Return-from-interrupt strobe from decode |
| flags_in | input | 16 | Current flags word; bit 9 is interrupt enable |
| cs_in | input | 16 | Current code segment |
| ip_in | input | 16 | Current instruction pointer (return address) |
| sp_in | input | 16 | Current stack pointer |
| ss_in | input | 16 | Current stack segment |
| busy | output | 1 | High from acceptance through the ctx_load cycle |
| mem_req | output | 1 | Memory word access request |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | 20 | Physical byte address (even) |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | Access completes at the clock edge where req and ack are both high |
| mem_rdata | input | 16 | Read data, valid with mem_ack |
| ctx_load | output | 1 | One-cycle strobe: core loads the values below |
| new_cs | output | 16 | Code segment to fetch from |
| new_ip | output | 16 | Instruction pointer to fetch from |
| new_sp | output | 16 | Updated stack pointer |
| new_flags | output | 16 | Updated flags word |

## Verification
The properties assume the core holds flags_in, cs_in, ip_in, sp_in and ss_in steady while busy is high, and that it copies the ctx_load values before the block next leaves idle. The bench meets this with a small register model that changes those inputs only in the ctx_load cycle or while the block is idle. The properties also assume mem_rdata is meaningful only alongside mem_ack. The bench's memory model drives rdata only on acknowledged cycles, with either zero or two wait cycles per word. Request pulses are driven one cycle at a time between clock edges, and some of them deliberately land while a sequence is running.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    localparam int WORD_W     = 16;
    localparam int SEG_SHIFT  = 4;
    localparam int ADDR_W     = WORD_W + SEG_SHIFT;
    localparam int WORD_BYTES = 2;
    localparam int FRAME_WORDS = 3;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] paddr_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PUSH_FL,
        ST_PUSH_CS,
        ST_PUSH_IP,
        ST_VEC_IP,
        ST_VEC_CS,
        ST_POP_IP,
        ST_POP_CS,
        ST_POP_FL,
        ST_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_IRET,
        SRC_NMI,
        SRC_IRQ
    } src_e;

    typedef struct packed {
        word_t flags;
        word_t cs;
        word_t ip;
        word_t sp;
        word_t ss;
    } cpu_ctx_t;

    // segment:offset to physical byte address
    function automatic paddr_t phys_addr(word_t seg, word_t off);
        return (paddr_t'(seg) << SEG_SHIFT) + paddr_t'(off);
    endfunction

    // successor of an access state once its word is acknowledged
    function automatic seq_state_e seq_next(seq_state_e s);
        case (s)
            ST_PUSH_FL: return ST_PUSH_CS;
            ST_PUSH_CS: return ST_PUSH_IP;
            ST_PUSH_IP: return ST_VEC_IP;
            ST_VEC_IP:  return ST_VEC_CS;
            ST_VEC_CS:  return ST_DONE;
            ST_POP_IP:  return ST_POP_CS;
            ST_POP_CS:  return ST_POP_FL;
            ST_POP_FL:  return ST_DONE;
            default:    return ST_IDLE;
        endcase
    endfunction

    function automatic logic is_access(seq_state_e s);
        return (s != ST_IDLE) && (s != ST_DONE);
    endfunction

    function automatic logic is_push(seq_state_e s);
        return (s == ST_PUSH_FL) || (s == ST_PUSH_CS) || (s == ST_PUSH_IP);
    endfunction

endpackage

// File: rtl/irq_seq_arb.sv
module irq_seq_arb
    import irq_seq_pkg::*;
#(
    parameter int TYPE_W   = 8,
    parameter int NMI_TYPE = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              idle,
    input  logic              iret_req,
    input  logic              nmi_req,
    input  logic              irq_req,
    input  logic [TYPE_W-1:0] irq_type,
    input  logic              if_flag,
    output src_e              src,
    output logic [TYPE_W-1:0] sel_type,
    output logic              nmi_pend,
    output logic              iret_pend
);

    logic nmi_pend_q;
    logic iret_pend_q;
    logic nmi_any;
    logic iret_any;

    always_comb begin
        nmi_any  = nmi_req | nmi_pend_q;
        iret_any = iret_req | iret_pend_q;
        src      = SRC_NONE;
        sel_type = irq_type;
        if (idle) begin
            if (iret_any) begin
                src = SRC_IRET;
            end else if (nmi_any) begin
                src      = SRC_NMI;
                sel_type = TYPE_W'(NMI_TYPE);
            end else if (irq_req && if_flag) begin
                src = SRC_IRQ;
            end
        end
    end

    // edge-type requests are held until the sequencer takes them
    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_pend_q  <= 1'b0;
            iret_pend_q <= 1'b0;
        end else begin
            nmi_pend_q  <= nmi_any  && (src != SRC_NMI);
            iret_pend_q <= iret_any && (src != SRC_IRET);
        end
    end

    assign nmi_pend  = nmi_pend_q;
    assign iret_pend = iret_pend_q;

endmodule

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
    import irq_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  src_e       src,
    input  logic       mem_ack,
    output seq_state_e state,
    output logic       ret_mode,
    output logic       start,
    output logic       step
);

    seq_state_e state_q;
    seq_state_e state_d;
    logic       ret_q;
    logic       ret_d;

    always_comb begin
        state_d = state_q;
        ret_d   = ret_q;
        start   = 1'b0;
        step    = is_access(state_q) && mem_ack;
        if (state_q == ST_IDLE) begin
            if (src == SRC_IRET) begin
                state_d = ST_POP_IP;
                ret_d   = 1'b1;
                start   = 1'b1;
            end else if (src != SRC_NONE) begin
                state_d = ST_PUSH_FL;
                ret_d   = 1'b0;
                start   = 1'b1;
            end
        end else if (state_q == ST_DONE) begin
            state_d = ST_IDLE;
        end else if (step) begin
            state_d = seq_next(state_q);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ret_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            ret_q   <= ret_d;
        end
    end

    assign state    = state_q;
    assign ret_mode = ret_q;

endmodule

// File: rtl/irq_seq_dp.sv
module irq_seq_dp
    import irq_seq_pkg::*;
#(
    parameter int TYPE_W = 8,
    parameter int IF_BIT = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  seq_state_e        state,
    input  logic              ret_mode,
    input  logic              start,
    input  logic              step,
    input  cpu_ctx_t          ctx_in,
    input  logic [TYPE_W-1:0] sel_type,
    input  word_t             mem_rdata,
    output paddr_t            mem_addr,
    output word_t             mem_wdata,
    output word_t             new_cs,
    output word_t             new_ip,
    output word_t             new_sp,
    output word_t             new_flags
);

    localparam int    PAD_W     = ADDR_W - TYPE_W - 2;
    localparam word_t OFF_1     = word_t'(WORD_BYTES);
    localparam word_t OFF_2     = word_t'(2 * WORD_BYTES);
    localparam word_t OFF_FRAME = word_t'(FRAME_WORDS * WORD_BYTES);
    localparam word_t IF_MASK   = word_t'(1) << IF_BIT;

    cpu_ctx_t          ctx_q;
    logic [TYPE_W-1:0] type_q;
    word_t             ip_q;
    word_t             cs_q;
    word_t             fl_q;
    paddr_t            vec_base;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q  <= '0;
            type_q <= '0;
            ip_q   <= '0;
            cs_q   <= '0;
            fl_q   <= '0;
        end else begin
            if (start) begin
                ctx_q  <= ctx_in;
                type_q <= sel_type;
            end
            if (step) begin
                case (state)
                    ST_VEC_IP, ST_POP_IP: ip_q <= mem_rdata;
                    ST_VEC_CS, ST_POP_CS: cs_q <= mem_rdata;
                    ST_POP_FL:            fl_q <= mem_rdata;
                    default: ;
                endcase
            end
        end
    end

    // four-byte entries: type scaled by four
    assign vec_base = {{PAD_W{1'b0}}, type_q, 2'b00};

    always_comb begin
        mem_addr  = '0;
        mem_wdata = '0;
        case (state)
            ST_PUSH_FL: begin
                mem_addr  = phys_addr(ctx_q.ss, ctx_q.sp - OFF_1);
                mem_wdata = ctx_q.flags;
            end
            ST_PUSH_CS: begin
                mem_addr  = phys_addr(ctx_q.ss, ctx_q.sp - OFF_2);
                mem_wdata = ctx_q.cs;
            end
            ST_PUSH_IP: begin
                mem_addr  = phys_addr(ctx_q.ss, ctx_q.sp - OFF_FRAME);
                mem_wdata = ctx_q.ip;
            end
            ST_VEC_IP:  mem_addr = vec_base;
            ST_VEC_CS:  mem_addr = vec_base + paddr_t'(WORD_BYTES);
            ST_POP_IP:  mem_addr = phys_addr(ctx_q.ss, ctx_q.sp);
            ST_POP_CS:  mem_addr = phys_addr(ctx_q.ss, ctx_q.sp + OFF_1);
            ST_POP_FL:  mem_addr = phys_addr(ctx_q.ss, ctx_q.sp + OFF_2);
            default: ;
        endcase
    end

    assign new_cs    = cs_q;
    assign new_ip    = ip_q;
    assign new_sp    = ret_mode ? (ctx_q.sp + OFF_FRAME) : (ctx_q.sp - OFF_FRAME);
    assign new_flags = ret_mode ? fl_q : (ctx_q.flags & ~IF_MASK);

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter int TYPE_W   = 8,
    parameter int IF_BIT   = 9,
    parameter int NMI_TYPE = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              irq_req,
    input  logic [TYPE_W-1:0] irq_type,
    input  logic              nmi_req,
    input  logic              iret_req,
    input  logic [WORD_W-1:0] flags_in,
    input  logic [WORD_W-1:0] cs_in,
    input  logic [WORD_W-1:0] ip_in,
    input  logic [WORD_W-1:0] sp_in,
    input  logic [WORD_W-1:0] ss_in,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              ctx_load,
    output logic [WORD_W-1:0] new_cs,
    output logic [WORD_W-1:0] new_ip,
    output logic [WORD_W-1:0] new_sp,
    output logic [WORD_W-1:0] new_flags
);

    seq_state_e        state;
    src_e              src;
    logic [TYPE_W-1:0] sel_type;
    logic              nmi_pend;
    logic              iret_pend;
    logic              ret_mode;
    logic              start;
    logic              step;
    cpu_ctx_t          ctx_in;

    assign ctx_in = '{flags: flags_in, cs: cs_in, ip: ip_in, sp: sp_in, ss: ss_in};

    irq_seq_arb #(
        .TYPE_W   (TYPE_W),
        .NMI_TYPE (NMI_TYPE)
    ) u_arb (
        .clk       (clk),
        .rst       (rst),
        .idle      (state == ST_IDLE),
        .iret_req  (iret_req),
        .nmi_req   (nmi_req),
        .irq_req   (irq_req),
        .irq_type  (irq_type),
        .if_flag   (flags_in[IF_BIT]),
        .src       (src),
        .sel_type  (sel_type),
        .nmi_pend  (nmi_pend),
        .iret_pend (iret_pend)
    );

    irq_seq_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .src      (src),
        .mem_ack  (mem_ack),
        .state    (state),
        .ret_mode (ret_mode),
        .start    (start),
        .step     (step)
    );

    irq_seq_dp #(
        .TYPE_W (TYPE_W),
        .IF_BIT (IF_BIT)
    ) u_dp (
        .clk       (clk),
        .rst       (rst),
        .state     (state),
        .ret_mode  (ret_mode),
        .start     (start),
        .step      (step),
        .ctx_in    (ctx_in),
        .sel_type  (sel_type),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .new_cs    (new_cs),
        .new_ip    (new_ip),
        .new_sp    (new_sp),
        .new_flags (new_flags)
    );

    assign busy     = (state != ST_IDLE);
    assign mem_req  = is_access(state);
    assign mem_we   = is_push(state);
    assign ctx_load = (state == ST_DONE);

endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk
    import irq_seq_pkg::*;
#(
    parameter int IF_BIT = 9
) (
    input logic   clk,
    input logic   rst,
    input logic   busy,
    input logic   mem_req,
    input logic   mem_we,
    input paddr_t mem_addr,
    input word_t  mem_wdata,
    input logic   mem_ack,
    input logic   ctx_load,
    input word_t  new_flags,
    input word_t  flags_in,
    input logic   irq_req,
    input logic   nmi_req,
    input logic   iret_req,
    input logic   nmi_pend,
    input logic   iret_pend,
    input logic   ret_mode
);

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R9

    AST_FLAGS_FIRST: assert property (@(posedge clk) disable iff (rst)
        (!$past(busy) && busy && mem_we) |-> (mem_req && mem_wdata == $past(flags_in))); // R1

    AST_ENTRY_IF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (ctx_load && !ret_mode) |-> !new_flags[IF_BIT]); // R3

    AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (rst)
        ctx_load |=> (!ctx_load && !busy)); // R3

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!busy && irq_req && !flags_in[IF_BIT] && !nmi_req && !nmi_pend && !iret_req && !iret_pend)
        |=> !busy); // R4

    AST_NMI_SERVED: assert property (@(posedge clk) disable iff (rst)
        (!busy && (nmi_req || nmi_pend) && !iret_req && !iret_pend) |=> (busy && mem_we)); // R5

    AST_NO_LOAD_MID: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !ctx_load); // R9

endmodule

bind irq_entry_seq irq_seq_chk #(.IF_BIT(IF_BIT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .ctx_load  (ctx_load),
    .new_flags (new_flags),
    .flags_in  (flags_in),
    .irq_req   (irq_req),
    .nmi_req   (nmi_req),
    .iret_req  (iret_req),
    .nmi_pend  (nmi_pend),
    .iret_pend (iret_pend),
    .ret_mode  (ret_mode)
);

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb;
    import irq_seq_pkg::*;

    localparam word_t IE = 16'h0200;

    logic   clk = 1'b0;
    logic   rst = 1'b1;
    logic   irq_req = 1'b0, nmi_req = 1'b0, iret_req = 1'b0;
    logic [7:0] irq_type = 8'h00;
    word_t  cpu_flags, cpu_cs, cpu_ip, cpu_sp, cpu_ss;
    logic   busy, mem_req, mem_we, mem_ack = 1'b0, ctx_load;
    paddr_t mem_addr;
    word_t  mem_wdata, mem_rdata = '0;
    word_t  new_cs, new_ip, new_sp, new_flags;

    always #5 clk = ~clk;

    irq_entry_seq u_dut (
        .clk(clk), .rst(rst), .irq_req(irq_req), .irq_type(irq_type),
        .nmi_req(nmi_req), .iret_req(iret_req),
        .flags_in(cpu_flags), .cs_in(cpu_cs), .ip_in(cpu_ip), .sp_in(cpu_sp), .ss_in(cpu_ss),
        .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .ctx_load(ctx_load), .new_cs(new_cs), .new_ip(new_ip), .new_sp(new_sp),
        .new_flags(new_flags)
    );

    int total = 0, bad = 0, acc_cnt = 0, load_cnt = 0, wait_cycles = 0, wcnt = 0, cyc = 0;
    string cur_req = "R10";
    word_t mem [int unsigned];

    typedef struct { string tag; logic we; paddr_t addr; word_t data; } acc_t;
    typedef struct { string tag; word_t cs; word_t ip; word_t sp; word_t flags; } red_t;
    acc_t acc_q[$];
    red_t red_q[$];

    task automatic check(string req, logic ok, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic paddr_t pa(word_t seg, word_t off);
        return ({4'b0, seg} << 4) + {4'b0, off};
    endfunction

    function automatic word_t rd(paddr_t a);
        return mem.exists(a) ? mem[a] : 16'h0000;
    endfunction

    // driver side of the scoreboard: expected traffic of one entry
    task automatic exp_entry(string tag, word_t f, word_t c, word_t i, word_t s, word_t ss, logic [7:0] t);
        string tw = (tag == "") ? "R1" : tag;
        string tr = (tag == "") ? "R2" : tag;
        string tx = (tag == "") ? "R3" : tag;
        paddr_t v = {10'b0, t, 2'b00};
        acc_q.push_back('{tw, 1'b1, pa(ss, s - 16'd2), f});
        acc_q.push_back('{tw, 1'b1, pa(ss, s - 16'd4), c});
        acc_q.push_back('{tw, 1'b1, pa(ss, s - 16'd6), i});
        acc_q.push_back('{tr, 1'b0, v, 16'h0000});
        acc_q.push_back('{tr, 1'b0, v + 20'd2, 16'h0000});
        red_q.push_back('{tx, rd(v + 20'd2), rd(v), s - 16'd6, f & ~IE});
    endtask

    task automatic exp_ret(string tag, word_t s, word_t ss);
        acc_q.push_back('{tag, 1'b0, pa(ss, s), 16'h0000});
        acc_q.push_back('{tag, 1'b0, pa(ss, s + 16'd2), 16'h0000});
        acc_q.push_back('{tag, 1'b0, pa(ss, s + 16'd4), 16'h0000});
        red_q.push_back('{tag, rd(pa(ss, s + 16'd2)), rd(pa(ss, s)), s + 16'd6, rd(pa(ss, s + 16'd4))});
    endtask

    // memory model: acknowledges after wait_cycles, drives rdata only with ack
    always begin
        @(negedge clk); #1;
        if (mem_req && !rst) begin
            if (wcnt >= wait_cycles) begin
                mem_ack = 1'b1;
                wcnt    = 0;
                if (mem_we) mem[mem_addr] = mem_wdata;
                mem_rdata = rd(mem_addr);
            end else begin
                mem_ack = 1'b0;
                wcnt++;
            end
        end else begin
            mem_ack = 1'b0;
            wcnt    = 0;
        end
    end

    // monitor side of the scoreboard
    always begin
        acc_t e;
        red_t r;
        @(negedge clk); #2;
        if (!rst && mem_req && mem_ack) begin
            acc_cnt++;
            if (acc_q.size() == 0) begin
                check(cur_req, 1'b0, "unexpected access at", 32'(mem_addr), 32'h0);
            end else begin
                e = acc_q.pop_front();
                check(e.tag, mem_addr == e.addr, "access address", 32'(mem_addr), 32'(e.addr));
                check(e.tag, mem_we == e.we, "access direction", 32'(mem_we), 32'(e.we));
                if (e.we) check(e.tag, mem_wdata == e.data, "pushed word", 32'(mem_wdata), 32'(e.data));
            end
        end
        if (!rst && ctx_load) begin
            load_cnt++;
            if (red_q.size() == 0) begin
                check(cur_req, 1'b0, "unexpected ctx_load ip", 32'(new_ip), 32'h0);
            end else begin
                r = red_q.pop_front();
                check(r.tag, new_cs == r.cs, "new_cs", 32'(new_cs), 32'(r.cs));
                check(r.tag, new_ip == r.ip, "new_ip", 32'(new_ip), 32'(r.ip));
                check(r.tag, new_sp == r.sp, "new_sp", 32'(new_sp), 32'(r.sp));
                check(r.tag, new_flags == r.flags, "new_flags", 32'(new_flags), 32'(r.flags));
            end
            cpu_cs = new_cs; cpu_ip = new_ip; cpu_sp = new_sp; cpu_flags = new_flags;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            bad++; total++;
            $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", cyc, 50000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wait_idle();
        do begin
            @(negedge clk); #3;
        end while (acc_q.size() != 0 || red_q.size() != 0 || busy);
    endtask

    task automatic fire_irq(logic [7:0] t);
        @(negedge clk);
        irq_type = t;
        irq_req  = 1'b1;
        do @(negedge clk); while (!busy);
        irq_req = 1'b0;
    endtask

    initial begin
        word_t f0, c0, i0, s0;
        int    n0, l0;
        logic  saw_busy;
        cpu_flags = 16'h0202; cpu_cs = 16'h1234; cpu_ip = 16'h5678;
        cpu_sp = 16'h0100; cpu_ss = 16'h2000;
        mem[20'h00084] = 16'hABCD; mem[20'h00086] = 16'h0F00;
        mem[20'h00008] = 16'h3333; mem[20'h0000A] = 16'h4444;
        mem[20'h00040] = 16'h5555; mem[20'h00042] = 16'h6666;

        // R10: outputs quiet in reset and just after
        repeat (3) @(negedge clk);
        #2;
        check("R10", busy == 1'b0, "busy in reset", 32'(busy), 0);
        check("R10", mem_req == 1'b0, "mem_req in reset", 32'(mem_req), 0);
        check("R10", ctx_load == 1'b0, "ctx_load in reset", 32'(ctx_load), 0);
        @(negedge clk); rst = 1'b0;
        @(negedge clk); #2;
        check("R10", busy == 1'b0 && mem_req == 1'b0, "busy/req after reset", 32'({busy, mem_req}), 0);

        // R1 R2 R3: maskable entry, type 21h, no wait states
        cur_req = "R1";
        exp_entry("", cpu_flags, cpu_cs, cpu_ip, cpu_sp, cpu_ss, 8'h21);
        fire_irq(8'h21);
        wait_idle();
        check("R3", cpu_sp == 16'h00FA, "sp after entry", 32'(cpu_sp), 32'h00FA);

        // R7: return pops the frame just built
        cur_req = "R7";
        exp_ret("R7", cpu_sp, cpu_ss);
        @(negedge clk); iret_req = 1'b1;
        @(negedge clk); iret_req = 1'b0;
        wait_idle();
        check("R7", cpu_flags == 16'h0202, "flags after return", 32'(cpu_flags), 32'h0202);
        check("R7", cpu_sp == 16'h0100 && cpu_cs == 16'h1234 && cpu_ip == 16'h5678,
              "sp/cs/ip after return", 32'({cpu_sp, cpu_ip}), 32'h01005678);

        // R8: return and interrupt in the same cycle, return first
        cur_req = "R8";
        mem[pa(cpu_ss, 16'h0100)] = 16'h1111;
        mem[pa(cpu_ss, 16'h0102)] = 16'h2222;
        mem[pa(cpu_ss, 16'h0104)] = 16'h0200;
        exp_ret("R8", 16'h0100, cpu_ss);
        exp_entry("R8", 16'h0200, 16'h2222, 16'h1111, 16'h0106, cpu_ss, 8'h10);
        @(negedge clk); iret_req = 1'b1; irq_req = 1'b1; irq_type = 8'h10;
        @(negedge clk); iret_req = 1'b0;
        wait_idle();
        irq_req = 1'b0;
        check("R8", cpu_ip == 16'h5555 && cpu_cs == 16'h6666, "handler after return+irq",
              32'({cpu_cs, cpu_ip}), 32'h66665555);

        // R4: maskable request ignored with interrupt enable clear
        cur_req = "R4";
        cpu_flags = 16'h0000;
        n0 = acc_cnt; l0 = load_cnt; saw_busy = 1'b0;
        @(negedge clk); irq_req = 1'b1; irq_type = 8'h21;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk); #2;
            if (busy) saw_busy = 1'b1;
        end
        irq_req = 1'b0;
        check("R4", saw_busy == 1'b0, "busy while masked", 32'(saw_busy), 0);
        check("R4", acc_cnt == n0 && load_cnt == l0, "accesses while masked", 32'(acc_cnt - n0), 0);

        // R5: NMI serviced with enable clear, type 2
        cur_req = "R5";
        exp_entry("R5", cpu_flags, cpu_cs, cpu_ip, cpu_sp, cpu_ss, 8'h02);
        @(negedge clk); nmi_req = 1'b1;
        @(negedge clk); nmi_req = 1'b0;
        wait_idle();
        check("R5", cpu_ip == 16'h3333 && cpu_cs == 16'h4444, "nmi handler",
              32'({cpu_cs, cpu_ip}), 32'h44443333);

        // R6: NMI and IRQ together, NMI wins, IRQ then held off
        cur_req = "R6";
        cpu_flags = 16'h0202;
        exp_entry("R6", cpu_flags, cpu_cs, cpu_ip, cpu_sp, cpu_ss, 8'h02);
        @(negedge clk); nmi_req = 1'b1; irq_req = 1'b1; irq_type = 8'h21;
        @(negedge clk); nmi_req = 1'b0;
        wait_idle();
        n0 = acc_cnt;
        repeat (10) @(negedge clk);
        irq_req = 1'b0;
        check("R6", acc_cnt == n0, "irq after nmi entry", 32'(acc_cnt - n0), 0);
        check("R6", cpu_ip == 16'h3333, "nmi taken first", 32'(cpu_ip), 32'h3333);

        // R9 and R5: wait states, NMI pulse while busy is remembered
        cur_req = "R9";
        wait_cycles = 2;
        cpu_flags = 16'h0202;
        f0 = cpu_flags; c0 = cpu_cs; i0 = cpu_ip; s0 = cpu_sp;
        exp_entry("R9", f0, c0, i0, s0, cpu_ss, 8'h21);
        exp_entry("R5", f0 & ~IE, 16'h0F00, 16'hABCD, s0 - 16'd6, cpu_ss, 8'h02);
        fire_irq(8'h21);
        @(negedge clk); nmi_req = 1'b1;
        @(negedge clk); nmi_req = 1'b0;
        wait_idle();
        check("R5", cpu_sp == s0 - 16'd12, "sp after two nested entries", 32'(cpu_sp), 32'(s0 - 16'd12));
        check("R9", acc_q.size() == 0, "scoreboard drained", 32'(acc_q.size()), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule